// File: doc/BRIEF.md
# Floating-Point Coprocessor Load/Store Transfer Sequencer

This block turns one 32-bit floating-point coprocessor data-transfer instruction, plus the current value of its base register, into a burst of 32-bit word accesses. It works out the first address from the indexing, direction and offset fields of the instruction. It then issues one word per cycle while the memory side holds `ready` high. Each word carries its address, the transfer direction, the floating-point register it belongs to and its position inside that register.

Two kinds of transfer are handled. A single-register transfer (coprocessor field 1) moves one, two or three words. A multi-register transfer (coprocessor field 2) moves one to four registers of three words each. When the last word is accepted, the block pulses `done`. If the instruction asks for writeback, it also pulses `wb_en` together with the updated base value and the base register number. An instruction the block cannot carry out raises `illegal` for one cycle and makes no access.

Top module: `fp_xfer_seq`

## Requirements
- R1: The first access address is `base_in` when bit 24 is 0 (post-index) and `base_in` plus or minus `4*instr[7:0]` when bit 24 is 1 (pre-index). The displacement is added when bit 23 is 1 and subtracted when bit 23 is 0, with 32-bit wraparound.
- R2: `acc_valid` rises in the cycle after an accepted `start`. One word is accepted per cycle in which `acc_valid` and `ready` are both high. Each next word's address is 4 above the last. While `ready` is low, the address, register index and word index hold.
- R3: With `instr[11:8]` equal to 1, the code `{instr[22], instr[15]}` gives the burst length: 00 gives 1 word, 01 gives 2 words and 10 gives 3 words. Code 11 is illegal.
- R4: With `instr[11:8]` equal to 2, the code `{instr[22], instr[15]}` gives the register count: 01 gives 1, 10 gives 2, 11 gives 3 and 00 gives 4. Each register takes 3 words.
- R5: `acc_freg` starts at `instr[14:12]`. In a single transfer it stays there and `acc_word` counts 0,1,2. In a multi transfer `acc_word` counts 0,1,2 and then returns to 0, and `acc_freg` steps by one modulo 8 after each third word.
- R6: `acc_load` equals `instr[20]` (1 = load, 0 = store) for every word of the burst.
- R7: `done` is high for exactly one cycle, the cycle after the last word is accepted, with `acc_valid` low. In that cycle `wb_en` equals `instr[21]`, `wb_value` is `base_in` plus or minus `4*instr[7:0]` in both indexing modes, and `wb_reg` is `instr[19:16]`. `wb_en` is never high without `done`.
- R8: Any coprocessor field other than 1 or 2, and the single-transfer code 11, raise `illegal` for one cycle, in the cycle after `start`. Such an instruction makes no access and produces no `done`.
- R9: A `start` pulse while a burst is in progress is ignored. The running burst completes with its own addresses, registers and writeback.
- R10: A synchronous `rst` returns the block to idle, with `busy`, `acc_valid`, `done`, `illegal` and `wb_en` low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a transfer when idle |
| instr | input | 32 | Data-transfer instruction word |
| base_in | input | 32 | Current base register value |
| ready | input | 1 | Memory accepts the presented word |
| busy | output | 1 | Burst in progress |
| acc_valid | output | 1 | A word access is presented |
| acc_addr | output | 32 | Byte address of the presented word |
| acc_load | output | 1 | 1 = load, 0 = store |
| acc_freg | output | 3 | Floating-point register index of the word |
| acc_word | output | 2 | Word index within that register |
| done | output | 1 | One-cycle end-of-burst pulse |
| illegal | output | 1 | One-cycle pulse for an unsupported instruction |
| wb_en | output | 1 | Base register writeback strobe |
| wb_reg | output | 4 | Base register number to write |
| wb_value | output | 32 | Updated base value |

## Verification
`start` is sampled at a rising edge. The first word, or the `illegal` pulse, is visible one cycle later. After that, each word is presented until the edge at which `ready` is seen high. `done` and the writeback fields follow one cycle after the edge that accepts the last word. The bench drives `start` and `ready` on falling edges and samples on the following falling edge. It compares each presented word against the expected word for the count of words already accepted, so a stalled word must repeat unchanged. It checks `done` in the cycle after the last acceptance and checks that `done` is gone one cycle later.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int ADDR_W     = 32;
    localparam int INSTR_W    = 32;
    localparam int OFF_W      = 8;
    localparam int WORD_SHIFT = 2;
    localparam int FREG_W     = 3;
    localparam int RN_W       = 4;
    localparam int CP_W       = 4;
    localparam int CNT_W      = 4;
    localparam int WIDX_W     = 2;
    localparam int REG_WORDS  = 3;

    // instruction field positions
    localparam int B_PRE    = 24;
    localparam int B_UP     = 23;
    localparam int B_CODEHI = 22;
    localparam int B_WB     = 21;
    localparam int B_LOAD   = 20;
    localparam int B_RN_LO  = 16;
    localparam int B_CODELO = 15;
    localparam int B_FR_LO  = 12;
    localparam int B_CP_LO  = 8;

    localparam logic [CP_W-1:0] CP_SINGLE = CP_W'(1);
    localparam logic [CP_W-1:0] CP_MULTI  = CP_W'(2);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] first_addr;
        logic [ADDR_W-1:0] next_base;
        logic [CNT_W-1:0]  words;
        logic [FREG_W-1:0] freg;
        logic [RN_W-1:0]   base_reg;
        logic              load;
        logic              wb;
        logic              multi;
    } xfer_cmd_t;

    function automatic logic [CNT_W-1:0] burst_words(input logic multi,
                                                     input logic [1:0] code);
        logic [CNT_W-1:0] n;
        if (multi) begin
            case (code)
                2'b01:   n = CNT_W'(REG_WORDS);
                2'b10:   n = CNT_W'(2 * REG_WORDS);
                2'b11:   n = CNT_W'(3 * REG_WORDS);
                default: n = CNT_W'(4 * REG_WORDS);
            endcase
        end else begin
            n = CNT_W'(code) + CNT_W'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
    import fpx_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  base,
    output xfer_cmd_t          cmd,
    output logic               bad
);

    localparam int PAD_W = ADDR_W - OFF_W - WORD_SHIFT;

    logic [CP_W-1:0]   cp;
    logic [1:0]        code;
    logic              is_single;
    logic              is_multi;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] moved;
    logic              unused_cond_bits;

    assign unused_cond_bits = ^instr[INSTR_W-1:B_PRE+1];

    assign cp        = instr[B_CP_LO +: CP_W];
    assign code      = {instr[B_CODEHI], instr[B_CODELO]};
    assign is_single = (cp == CP_SINGLE);
    assign is_multi  = (cp == CP_MULTI);
    assign disp      = {{PAD_W{1'b0}}, instr[OFF_W-1:0], {WORD_SHIFT{1'b0}}};
    assign moved     = instr[B_UP] ? (base + disp) : (base - disp);

    always_comb begin
        cmd.first_addr = instr[B_PRE] ? moved : base;
        cmd.next_base  = moved;
        cmd.words      = burst_words(is_multi, code);
        cmd.freg       = instr[B_FR_LO +: FREG_W];
        cmd.base_reg   = instr[B_RN_LO +: RN_W];
        cmd.load       = instr[B_LOAD];
        cmd.wb         = instr[B_WB];
        cmd.multi      = is_multi;
        bad            = !(is_single || is_multi) || (is_single && code == 2'b11);
    end

endmodule

// File: rtl/fpx_burst.sv
module fpx_burst
    import fpx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  xfer_cmd_t         cmd,
    input  logic              cmd_bad,
    input  logic              ready,
    output logic              running,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_load,
    output logic [FREG_W-1:0] cur_freg,
    output logic [WIDX_W-1:0] cur_word,
    output logic              fin,
    output logic              rej,
    output logic              wb_fire,
    output logic [RN_W-1:0]   wb_rn,
    output logic [ADDR_W-1:0] wb_val
);

    localparam logic [WIDX_W-1:0] LAST_IN_REG = WIDX_W'(REG_WORDS - 1);

    seq_state_t        state;
    logic [CNT_W-1:0]  left;
    logic              hold_multi;
    logic              hold_wb;
    logic              fin_q;
    logic              rej_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            left       <= '0;
            cur_addr   <= '0;
            cur_freg   <= '0;
            cur_word   <= '0;
            cur_load   <= 1'b0;
            hold_multi <= 1'b0;
            hold_wb    <= 1'b0;
            wb_rn      <= '0;
            wb_val     <= '0;
            fin_q      <= 1'b0;
            rej_q      <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            rej_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (cmd_bad) begin
                            rej_q <= 1'b1;
                        end else begin
                            state      <= ST_RUN;
                            left       <= cmd.words;
                            cur_addr   <= cmd.first_addr;
                            cur_freg   <= cmd.freg;
                            cur_word   <= '0;
                            cur_load   <= cmd.load;
                            hold_multi <= cmd.multi;
                            hold_wb    <= cmd.wb;
                            wb_rn      <= cmd.base_reg;
                            wb_val     <= cmd.next_base;
                        end
                    end
                end
                ST_RUN: begin
                    if (ready) begin
                        if (left == CNT_W'(1)) begin
                            state <= ST_IDLE;
                            fin_q <= 1'b1;
                        end else begin
                            left     <= left - CNT_W'(1);
                            cur_addr <= cur_addr + STEP;
                            if (hold_multi && cur_word == LAST_IN_REG) begin
                                cur_word <= '0;
                                cur_freg <= cur_freg + FREG_W'(1);
                            end else begin
                                cur_word <= cur_word + WIDX_W'(1);
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign running = (state == ST_RUN);
    assign fin     = fin_q;
    assign rej     = rej_q;
    assign wb_fire = fin_q && hold_wb;

endmodule

// File: rtl/fp_xfer_seq.sv
module fp_xfer_seq
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  base_in,
    input  logic               ready,
    output logic               busy,
    output logic               acc_valid,
    output logic [ADDR_W-1:0]  acc_addr,
    output logic               acc_load,
    output logic [FREG_W-1:0]  acc_freg,
    output logic [WIDX_W-1:0]  acc_word,
    output logic               done,
    output logic               illegal,
    output logic               wb_en,
    output logic [RN_W-1:0]    wb_reg,
    output logic [ADDR_W-1:0]  wb_value
);

    xfer_cmd_t cmd;
    logic      cmd_bad;
    logic      running;

    fpx_decode u_dec (
        .instr (instr),
        .base  (base_in),
        .cmd   (cmd),
        .bad   (cmd_bad)
    );

    fpx_burst u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (cmd),
        .cmd_bad  (cmd_bad),
        .ready    (ready),
        .running  (running),
        .cur_addr (acc_addr),
        .cur_load (acc_load),
        .cur_freg (acc_freg),
        .cur_word (acc_word),
        .fin      (done),
        .rej      (illegal),
        .wb_fire  (wb_en),
        .wb_rn    (wb_reg),
        .wb_val   (wb_value)
    );

    assign busy      = running;
    assign acc_valid = running;

endmodule

// File: rtl/fpx_xfer_chk.sv
module fpx_xfer_chk
    import fpx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              acc_valid,
    input logic              ready,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [FREG_W-1:0] acc_freg,
    input logic [WIDX_W-1:0] acc_word,
    input logic              done,
    input logic              illegal,
    input logic              wb_en
);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !ready |=> acc_valid && $stable(acc_addr)
                                && $stable(acc_freg) && $stable(acc_word));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && ready |=> !acc_valid || acc_addr == $past(acc_addr) + STEP);

    // R5
    word_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && ready && acc_word == WIDX_W'(REG_WORDS - 1)
        |=> !acc_valid || (acc_word == '0 && acc_freg == $past(acc_freg) + FREG_W'(1)));

    // R5
    word_range_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> acc_word < WIDX_W'(REG_WORDS));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !acc_valid && !busy);

    // R7
    wb_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    // R8
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !acc_valid && !done && !wb_en);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !busy && !acc_valid && !done && !illegal && !wb_en);

endmodule

bind fp_xfer_seq fpx_xfer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .acc_valid (acc_valid),
    .ready     (ready),
    .acc_addr  (acc_addr),
    .acc_freg  (acc_freg),
    .acc_word  (acc_word),
    .done      (done),
    .illegal   (illegal),
    .wb_en     (wb_en)
);

// File: tb/fp_xfer_seq_test.sv
`timescale 1ns/1ps
module fp_xfer_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_in = '0;
    logic        ready = 1'b0;
    logic        busy, acc_valid, acc_load, done, illegal, wb_en;
    logic [31:0] acc_addr, wb_value;
    logic [2:0]  acc_freg;
    logic [1:0]  acc_word;
    logic [3:0]  wb_reg;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    fp_xfer_seq uut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .base_in(base_in),
        .ready(ready), .busy(busy), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_load(acc_load), .acc_freg(acc_freg), .acc_word(acc_word),
        .done(done), .illegal(illegal), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_value(wb_value)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit pre, input bit up, input bit wb,
                                       input bit ld, input logic [1:0] code,
                                       input logic [3:0] cp, input logic [2:0] fr,
                                       input logic [3:0] rn, input logic [7:0] off);
        logic [31:0] w;
        w        = 32'hEC00_0000;
        w[24]    = pre;
        w[23]    = up;
        w[22]    = code[1];
        w[21]    = wb;
        w[20]    = ld;
        w[19:16] = rn;
        w[15]    = code[0];
        w[14:12] = fr;
        w[11:8]  = cp;
        w[7:0]   = off;
        return w;
    endfunction

    task automatic do_xfer(input logic [31:0] ins, input logic [31:0] b,
                           input bit stall, input bit poke);
        logic [3:0]  cp;
        logic [1:0]  code;
        bit          multi, bad;
        int          nw, k, cyc;
        logic [31:0] disp, moved, first, e_addr;
        logic [2:0]  e_freg;
        logic [1:0]  e_word;
        cp    = ins[11:8];
        code  = {ins[22], ins[15]};
        multi = (cp == 4'd2);
        bad   = !(cp == 4'd1 || multi) || (cp == 4'd1 && code == 2'b11);
        if (multi) nw = (code == 2'b00) ? 12 : 3 * int'(code);
        else       nw = int'(code) + 1;
        disp  = {22'd0, ins[7:0], 2'b00};
        moved = ins[23] ? b + disp : b - disp;
        first = ins[24] ? moved : b;

        @(negedge clk);
        instr = ins; base_in = b; start = 1'b1; ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            chk(illegal == 1'b1, "R8 illegal pulse (R3 code 11 case)", 32'(illegal), 32'd1);
            chk(acc_valid == 1'b0, "R8 no access", 32'(acc_valid), 32'd0);
            @(negedge clk);
            chk(!illegal && !done && !acc_valid && !wb_en, "R8 quiet after pulse",
                {illegal, done, acc_valid, wb_en}, 32'd0);
            return;
        end
        chk(illegal == 1'b0, "R8 no illegal on valid", 32'(illegal), 32'd0);
        k = 0; cyc = 0;
        while (k < nw && cyc < 200) begin
            e_addr = first + 32'(4 * k);
            e_freg = multi ? ins[14:12] + 3'(k / 3) : ins[14:12];
            e_word = multi ? 2'(k % 3) : 2'(k);
            chk(acc_valid == 1'b1, "R2 word presented", 32'(acc_valid), 32'd1);
            chk(acc_addr == e_addr, "R1 R2 address", acc_addr, e_addr);
            chk(acc_freg == e_freg && acc_word == e_word, "R5 register and word index",
                {acc_freg, acc_word}, {e_freg, e_word});
            chk(acc_load == ins[20], "R6 direction", 32'(acc_load), 32'(ins[20]));
            chk(done == 1'b0, "R7 no early done", 32'(done), 32'd0);
            if (poke && cyc == 1) begin
                start = 1'b1; instr = ins ^ 32'h0080_F0FF; base_in = b + 32'h40;
            end else begin
                start = 1'b0;
            end
            ready = stall ? cyc[0] : 1'b1;
            if (ready) k++;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; ready = 1'b0;
        chk(done == 1'b1 && acc_valid == 1'b0, "R3 R4 R7 done after last word",
            {done, acc_valid}, 32'd2);
        chk(wb_en == ins[21], "R7 writeback strobe", 32'(wb_en), 32'(ins[21]));
        if (ins[21]) begin
            chk(wb_value == moved, "R7 writeback value (R9 if poked)", wb_value, moved);
            chk(wb_reg == ins[19:16], "R7 writeback register", 32'(wb_reg), 32'(ins[19:16]));
        end
        @(negedge clk);
        chk(done == 1'b0 && wb_en == 1'b0, "R7 single-cycle done", {done, wb_en}, 32'd0);
        chk(acc_valid == 1'b0, "R9 no second burst from ignored start",
            32'(acc_valid), 32'd0);
    endtask

    task automatic reset_mid_burst();
        @(negedge clk);
        instr = mk(1, 1, 1, 1, 2'b00, 4'd2, 3'd0, 4'd3, 8'd4);
        base_in = 32'h2000; start = 1'b1; ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(acc_valid == 1'b1, "R10 burst running before reset", 32'(acc_valid), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !acc_valid && !done && !illegal && !wb_en, "R10 idle in reset",
            {busy, acc_valid, done, illegal, wb_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !acc_valid && !done && !wb_en, "R10 stays idle after reset",
            {busy, acc_valid, done, wb_en}, 32'd0);
        ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        vectors++;
        $display("FAIL R2 watchdog expired act=0 exp=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !acc_valid && !done && !illegal && !wb_en, "R10 reset state",
            {busy, acc_valid, done, illegal, wb_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !acc_valid, "R10 idle after release", {busy, acc_valid}, 32'd0);

        // R1 R3: single word, pre-index up, writeback, load
        do_xfer(mk(1, 1, 1, 1, 2'b00, 4'd1, 3'd2, 4'd5, 8'h10), 32'h0000_1000, 0, 0);
        // R1 R3: two words, post-index down, store, stalled
        do_xfer(mk(0, 0, 1, 0, 2'b01, 4'd1, 3'd7, 4'd9, 8'h03), 32'h0000_8000, 1, 0);
        // R3: three words, pre-index down, no writeback
        do_xfer(mk(1, 0, 0, 1, 2'b10, 4'd1, 3'd4, 4'd1, 8'h02), 32'h0000_0100, 0, 0);
        // R3 R8: single code 11 is illegal
        do_xfer(mk(1, 1, 1, 1, 2'b11, 4'd1, 3'd0, 4'd0, 8'h01), 32'h0000_0040, 0, 0);
        // R4 R5: four registers from f6 wrap modulo 8, stalled
        do_xfer(mk(1, 1, 1, 0, 2'b00, 4'd2, 3'd6, 4'd13, 8'h0C), 32'h0001_0000, 1, 0);
        // R4: one register
        do_xfer(mk(0, 1, 0, 1, 2'b01, 4'd2, 3'd1, 4'd2, 8'h03), 32'h0000_0200, 0, 0);
        // R4: two registers, post-index up, writeback
        do_xfer(mk(0, 1, 1, 1, 2'b10, 4'd2, 3'd3, 4'd4, 8'h06), 32'h0000_0300, 0, 0);
        // R4: three registers
        do_xfer(mk(1, 0, 1, 0, 2'b11, 4'd2, 3'd5, 4'd6, 8'h09), 32'h0000_0400, 1, 0);
        // R8: coprocessor 3 is illegal
        do_xfer(mk(1, 1, 1, 1, 2'b00, 4'd3, 3'd0, 4'd0, 8'h01), 32'h0000_0040, 0, 0);
        // R8: coprocessor 0 is illegal
        do_xfer(mk(0, 0, 0, 0, 2'b01, 4'd0, 3'd0, 4'd0, 8'h00), 32'h0000_0040, 0, 0);
        // R9: start during a burst is ignored
        do_xfer(mk(1, 1, 1, 1, 2'b10, 4'd2, 3'd0, 4'd7, 8'h01), 32'h0000_5000, 0, 1);
        // R1 R7: maximum offset, subtraction wraps below zero
        do_xfer(mk(1, 0, 1, 1, 2'b00, 4'd1, 3'd0, 4'd8, 8'hFF), 32'h0000_0010, 0, 0);
        // R10: reset during a burst
        reset_mid_burst();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule